// File: doc/BRIEF.md
# Floating-Point Conditional Branch Resolver

This block resolves a floating-point conditional branch in a delayed-branch pipeline. It takes the branch instruction word, the address of the branch itself and the current two-bit floating-point condition code. In a single combinational pass it decides whether the branch is taken and forms the branch destination from a signed 22-bit word displacement. It also produces the next program-counter pair and says whether the instruction in the delay slot must be squashed.

The condition field selects one of sixteen subsets of the four comparison outcomes: equal, less, greater and unordered. The upper eight conditions are the complements of the lower eight. An internal flow selector places every branch in one of four named outcomes:
- FLOW_FALL_RUN: not taken, delay slot runs.
- FLOW_FALL_SKIP: not taken, delay slot squashed.
- FLOW_JUMP_RUN: taken, delay slot runs, then execution continues at the destination.
- FLOW_JUMP_SKIP: branch-always with the annul bit set, which goes straight to the destination.

The decisions between them are:
- "untaken" selects between the two FALL outcomes, using the annul bit.
- "taken-always-annulled" leads to FLOW_JUMP_SKIP.
- "taken-other" leads to FLOW_JUMP_RUN.

The pipeline loads the returned pair as its new (PC, nPC).

Top module: `fbr_next_pc`

## Requirements
- R1: The condition is taken from instruction bits 28:25, the annul flag from bit 29 and the displacement from bits 21:0. The condition code is encoded 0 equal, 1 less, 2 greater, 3 unordered.
- R2: Condition 0 is never taken and condition 8 is always taken, whatever the condition code.
- R3: Conditions 1 to 7 are taken on these outcomes: 1 less/greater/unordered, 2 less/greater, 3 less/unordered, 4 less, 5 unordered/greater, 6 greater, 7 unordered.
- R4: Conditions 9 to 15 are taken on these outcomes: 9 equal, 10 equal/unordered, 11 equal/greater, 12 equal/greater/unordered, 13 equal/less, 14 equal/less/unordered, 15 equal/less/greater.
- R5: target equals pc plus the sign-extended displacement times four, modulo 2^32.
- R6: An untaken branch with annul clear gives next_pc = pc+4, next_npc = pc+8 and annul_slot = 0.
- R7: An untaken branch with annul set gives next_pc = pc+8, next_npc = pc+12 and annul_slot = 1.
- R8: Condition 8 with annul set gives next_pc = target, next_npc = target+4 and annul_slot = 1.
- R9: Any other taken branch gives next_pc = pc+4, next_npc = target and annul_slot = 0.
- R10: Instruction bits 31:30 and 24:22 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Branch instruction word |
| pc | input | 32 | Address of the branch instruction |
| fcc | input | 2 | Current floating-point condition code |
| taken | output | 1 | Branch condition satisfied |
| target | output | 32 | Branch destination address |
| next_pc | output | 32 | Address of the next instruction to execute |
| next_npc | output | 32 | Address of the instruction after that |
| annul_slot | output | 1 | Delay-slot instruction is squashed |

## Verification
The checker evaluates its properties combinationally, so it assumes the three inputs carry known two-state values and change together rather than in staggered steps within a time step. It also relies on address arithmetic wrapping at 32 bits. The stimulus changes all inputs in one step, shortly after a clock edge. It drives only fully defined values, including the sign boundaries of the displacement and a branch address near the top of memory, so the wrap cases stay legal for the properties.

// File: rtl/fbr_pkg.sv
`timescale 1ns/1ps
package fbr_pkg;

    // Comparison outcome held in the floating-point condition code.
    typedef enum logic [1:0] {
        FCC_EQ = 2'd0,
        FCC_LT = 2'd1,
        FCC_GT = 2'd2,
        FCC_UN = 2'd3
    } fcc_t;

    // Control-flow outcome of one branch.
    typedef enum logic [1:0] {
        FLOW_FALL_RUN,
        FLOW_FALL_SKIP,
        FLOW_JUMP_RUN,
        FLOW_JUMP_SKIP
    } flow_t;

    localparam int COND_W      = 4;
    localparam int COND_LSB    = 25;
    localparam int ANNUL_BIT   = 29;
    localparam int DISP_W      = 22;
    localparam logic [COND_W-1:0] COND_ALWAYS = 4'd8;

endpackage

// File: rtl/fbr_cond_eval.sv
`timescale 1ns/1ps
module fbr_cond_eval
    import fbr_pkg::*;
#(
    parameter int CW = COND_W
) (
    input  logic [CW-1:0] cond,
    input  logic [1:0]    fcc,
    output logic          hit
);

    // Lower-half subsets as a mask indexed by the code: {UN, GT, LT, EQ}.
    // The upper half of the condition space is the complement.
    function automatic logic [3:0] lower_set(input logic [CW-2:0] sel);
        logic [3:0] m;
        unique case (sel)
            3'd0: m = 4'b0000;
            3'd1: m = 4'b1110;
            3'd2: m = 4'b0110;
            3'd3: m = 4'b1010;
            3'd4: m = 4'b0010;
            3'd5: m = 4'b1100;
            3'd6: m = 4'b0100;
            default: m = 4'b1000;
        endcase
        return m;
    endfunction

    logic [3:0] subset;

    always_comb begin
        subset = lower_set(cond[CW-2:0]);
        hit    = cond[CW-1] ^ subset[fcc];
    end

endmodule

// File: rtl/fbr_target_calc.sv
`timescale 1ns/1ps
module fbr_target_calc #(
    parameter int ADDR_W = 32,
    parameter int DW     = 22,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DW-1:0]     disp,
    output logic [ADDR_W-1:0] target
);

    localparam int EXT_W = ADDR_W - DW - SHIFT;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = {{EXT_W{disp[DW-1]}}, disp, {SHIFT{1'b0}}};
        target = pc + offset;
    end

endmodule

// File: rtl/fbr_flow_sel.sv
`timescale 1ns/1ps
module fbr_flow_sel
    import fbr_pkg::*;
(
    input  logic  hit,
    input  logic  annul,
    input  logic  is_always,
    output flow_t flow
);

    always_comb begin
        if (!hit)
            flow = annul ? FLOW_FALL_SKIP : FLOW_FALL_RUN;   // untaken
        else if (annul && is_always)
            flow = FLOW_JUMP_SKIP;                          // taken-always-annulled
        else
            flow = FLOW_JUMP_RUN;                           // taken-other
    end

endmodule

// File: rtl/fbr_next_pc.sv
`timescale 1ns/1ps
module fbr_next_pc
    import fbr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [1:0]        fcc,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] next_npc,
    output logic              annul_slot
);

    localparam int SHIFT = $clog2(INSN_BYTES);
    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSN_BYTES);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSN_BYTES);
    localparam logic [ADDR_W-1:0] STEP3 = ADDR_W'(3 * INSN_BYTES);

    logic [COND_W-1:0] cond_f;
    logic              annul_f;
    logic [DISP_W-1:0] disp_f;
    logic              hit;
    flow_t             flow;

    assign cond_f  = instr[COND_LSB +: COND_W];
    assign annul_f = instr[ANNUL_BIT];
    assign disp_f  = instr[DISP_W-1:0];

    fbr_cond_eval #(.CW(COND_W)) u_cond (
        .cond (cond_f),
        .fcc  (fcc),
        .hit  (hit)
    );

    fbr_target_calc #(.ADDR_W(ADDR_W), .DW(DISP_W), .SHIFT(SHIFT)) u_tgt (
        .pc     (pc),
        .disp   (disp_f),
        .target (target)
    );

    fbr_flow_sel u_flow (
        .hit       (hit),
        .annul     (annul_f),
        .is_always (cond_f == COND_ALWAYS),
        .flow      (flow)
    );

    assign taken = hit;

    always_comb begin
        unique case (flow)
            FLOW_FALL_RUN: begin
                next_pc    = pc + STEP1;
                next_npc   = pc + STEP2;
                annul_slot = 1'b0;
            end
            FLOW_FALL_SKIP: begin
                next_pc    = pc + STEP2;
                next_npc   = pc + STEP3;
                annul_slot = 1'b1;
            end
            FLOW_JUMP_SKIP: begin
                next_pc    = target;
                next_npc   = target + STEP1;
                annul_slot = 1'b1;
            end
            default: begin
                next_pc    = pc + STEP1;
                next_npc   = target;
                annul_slot = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fbr_next_pc_chk.sv
`timescale 1ns/1ps
module fbr_next_pc_chk #(
    parameter int ADDR_W = 32
) (
    input logic [31:0]       instr,
    input logic [ADDR_W-1:0] pc,
    input logic [1:0]        fcc,
    input logic              taken,
    input logic [ADDR_W-1:0] target,
    input logic [ADDR_W-1:0] next_pc,
    input logic [ADDR_W-1:0] next_npc,
    input logic              annul_slot
);

    always_comb begin
        // R2
        never_taken_chk: assert (!(instr[28:25] == 4'd0 && taken))
            else $error("condition 0 taken");
        // R2
        always_taken_chk: assert (!(instr[28:25] == 4'd8 && !taken))
            else $error("condition 8 not taken");
        // R5
        target_align_chk: assert (target[1:0] == pc[1:0])
            else $error("target misaligned relative to pc");
        // R6
        fall_pair_chk: assert (taken || (next_npc == next_pc + 32'd4 &&
                               (next_pc == pc + 32'd4 || next_pc == pc + 32'd8)))
            else $error("untaken pair wrong");
        // R7
        fall_skip_chk: assert (taken || !instr[29] || annul_slot)
            else $error("untaken annulled branch ran its slot");
        // R9
        jump_run_chk: assert (!taken || annul_slot ||
                              (next_pc == pc + 32'd4 && next_npc == target))
            else $error("taken branch with slot has wrong pair");
        // R8
        jump_skip_chk: assert (!(taken && annul_slot) ||
                               (instr[29] && instr[28:25] == 4'd8 &&
                                next_pc == target && next_npc == target + 32'd4))
            else $error("slot squashed on wrong taken branch");
    end

endmodule

bind fbr_next_pc fbr_next_pc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .instr      (instr),
    .pc         (pc),
    .fcc        (fcc),
    .taken      (taken),
    .target     (target),
    .next_pc    (next_pc),
    .next_npc   (next_npc),
    .annul_slot (annul_slot)
);

// File: tb/sim_fbr_next_pc.sv
`timescale 1ns/1ps
module sim_fbr_next_pc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc = '0;
    logic [1:0]  fcc = '0;
    logic        taken;
    logic [31:0] target, next_pc, next_npc;
    logic        annul_slot;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    fbr_next_pc u0 (
        .instr(instr), .pc(pc), .fcc(fcc),
        .taken(taken), .target(target), .next_pc(next_pc),
        .next_npc(next_npc), .annul_slot(annul_slot)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural model of the condition table; code 0 E, 1 L, 2 G, 3 U.
    function automatic bit ref_taken(input int c, input int code);
        bit e, l, g, u;
        e = (code == 0); l = (code == 1); g = (code == 2); u = (code == 3);
        case (c)
            0:  return 0;
            1:  return l || g || u;
            2:  return l || g;
            3:  return l || u;
            4:  return l;
            5:  return u || g;
            6:  return g;
            7:  return u;
            8:  return 1;
            9:  return e;
            10: return e || u;
            11: return e || g;
            12: return e || g || u;
            13: return e || l;
            14: return e || l || u;
            default: return e || l || g;
        endcase
    endfunction

    // Drive one branch, then check every output at the next falling edge.
    task automatic run(input int c, input int code, input bit a,
                       input int disp, input logic [31:0] p,
                       input logic [4:0] junk, input string tag_x);
        int          d;
        bit          tk;
        logic [31:0] tgt, epc, enpc;
        bit          esk;
        string       ttag, ftag;
        @(posedge clk);
        #1;
        instr = {junk[4:3], a, 4'(c), junk[2:0], 22'(disp)};
        pc    = p;
        fcc   = 2'(code);
        @(negedge clk);
        d   = (disp >= (1 << 21)) ? disp - (1 << 22) : disp;
        tgt = p + 32'(d * 4);
        tk  = ref_taken(c, code);
        if (!tk && !a)        begin epc = p + 4;  enpc = p + 8;   esk = 0; ftag = "R6"; end
        else if (!tk)         begin epc = p + 8;  enpc = p + 12;  esk = 1; ftag = "R7"; end
        else if (c == 8 && a) begin epc = tgt;    enpc = tgt + 4; esk = 1; ftag = "R8"; end
        else                  begin epc = p + 4;  enpc = tgt;     esk = 0; ftag = "R9"; end
        ttag = (c == 0 || c == 8) ? "R2" : (c < 8) ? "R3" : "R4";
        if (tag_x != "") begin ttag = tag_x; ftag = tag_x; end
        chk(ttag, "taken", 32'(taken), 32'(tk));
        chk((tag_x != "") ? tag_x : "R5", "target", target, tgt);
        chk(ftag, "next_pc", next_pc, epc);
        chk(ftag, "next_npc", next_npc, enpc);
        chk(ftag, "annul_slot", 32'(annul_slot), 32'(esk));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: all-zero word is a never branch without annul (R6).
        @(negedge clk);
        chk("R6", "idle taken", 32'(taken), 32'd0);
        chk("R6", "idle next_pc", next_pc, 32'd4);
        chk("R6", "idle annul_slot", 32'(annul_slot), 32'd0);

        // Full sweep: every condition, every code, both annul settings.
        for (int c = 0; c < 16; c++)
            for (int code = 0; code < 4; code++)
                for (int a = 0; a < 2; a++)
                    run(c, code, a[0], (c * 40961 + code * 977 + a * 13) & 32'h3F_FFFF,
                        32'h0040_0000 + 32'(c * 256 + code * 16 + a * 4), 5'd0, "");

        // R5 displacement boundaries and address wrap.
        run(8, 0, 0, 32'h1F_FFFF, 32'h1000_0000, 5'd0, "R5");
        run(8, 0, 0, 32'h20_0000, 32'h1000_0000, 5'd0, "R5");
        run(8, 0, 0, 32'h3F_FFFF, 32'h0000_0000, 5'd0, "R5");
        run(8, 0, 0, 0,           32'h0000_1234, 5'd0, "R5");
        run(9, 0, 0, 32'h00_0010, 32'hFFFF_FFFC, 5'd0, "R5");

        // R8 branch-always annulled with a backward displacement.
        run(8, 3, 1, 32'h3F_FFF0, 32'h0000_8000, 5'd0, "R8");

        // R1 field positions with distinctive values.
        run(13, 1, 1, 32'h15_5555, 32'h0000_2000, 5'd0, "R1");
        run(7,  3, 1, 32'h2A_AAAA, 32'h0000_3000, 5'd0, "R1");

        // R10 unused bits set: outputs must match the clean reference.
        run(4,  1, 0, 32'h00_0100, 32'h0000_4000, 5'b11111, "R10");
        run(4,  0, 1, 32'h00_0100, 32'h0000_4000, 5'b10101, "R10");
        run(8,  2, 1, 32'h30_0000, 32'h0000_5000, 5'b01010, "R10");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule